// File: doc/BRIEF.md
# SPI Byte Slave with Write-Collision Guard

This block is the slave end of a four-wire serial link. An external master drives the serial clock, the serial data input and an active-low select line. The block shifts one byte in from the master and, in the same frame, one byte out on its serial data output, most significant bit first. Two configuration inputs set the clock polarity (the idle level of the clock) and the clock phase (whether data is captured on the leading or the trailing clock edge). The three incoming pins pass through two-flop synchronizers and are sampled in the system clock domain. The system clock must run at least four times faster than the serial clock.

On the local side the host writes the byte to be sent into a data register and reads the last received byte. Completion of a byte sets a done flag, which a host read clears. While the select line is low the data register is frozen. A host write made then is dropped and sets a sticky collision flag, which the host clears with a separate strobe. With phase 0 the select line must be raised between bytes. With phase 1 it may stay low across back-to-back bytes.

The controller has three states. IDLE: select is high and the output enable is off. XFER: a byte is being shifted. HOLD: a phase-0 byte has finished and the block waits for select to rise. The transitions are: IDLE to XFER when the synchronized select goes low (the transmit shifter loads from the data register); XFER to IDLE when select rises (abort or normal end); XFER to HOLD on the eighth capture edge with phase 0; XFER to XFER on the eighth capture edge with phase 1 (reload for the next byte); HOLD to IDLE when select rises.

Top module: `spi_byte_slave`

## Requirements
- R1: After reset, miso_oe_o is 0, xfer_done_o is 0, collide_o is 0 and rd_data_o is 0x00.
- R2: In each of the four modes a frame of eight capture edges exchanges a byte in both directions, MSB first. The capture edge is the leading edge (the first transition away from the idle level) when cfg_cpha_i=0 and the trailing edge when cfg_cpha_i=1. The idle level of sck_i is 0 when cfg_cpol_i=0 and 1 when cfg_cpol_i=1.
- R3: With cfg_cpha_i=0, miso_o carries bit 7 of the data register within four system clocks of ss_n_i falling, before any clock edge, and it advances to the next bit on each trailing edge.
- R4: With cfg_cpha_i=1, miso_o presents bit 7 for the first leading edge and advances on each later leading edge of the byte.
- R5: After the eighth capture edge, rd_data_o holds the received byte and xfer_done_o is 1. A one-cycle rd_en_i pulse clears xfer_done_o.
- R6: A wr_en_i pulse while ss_n_i is low (or a frame is still open) is rejected. It sets collide_o and leaves the data register unchanged, so later frames still shift out the old byte.
- R7: collide_o stays set until a collide_clr_i pulse clears it.
- R8: With cfg_cpha_i=0, only one byte is exchanged per select-low period. Further clock edges are ignored until ss_n_i rises.
- R9: With cfg_cpha_i=1, consecutive bytes may be exchanged with ss_n_i held low. Each byte completes with xfer_done_o set and shifts out the data register again.
- R10: While ss_n_i is high, miso_oe_o is 0 and activity on sck_i and mosi_i changes neither xfer_done_o nor rd_data_o.
- R11: If ss_n_i rises before the eighth capture edge, the partial byte is discarded: xfer_done_o stays 0 and rd_data_o keeps its value.
- R12: A wr_en_i pulse while ss_n_i has been high for at least four system clocks is accepted without setting collide_o.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol_i | input | 1 | Clock idle level: 0 idles low, 1 idles high |
| cfg_cpha_i | input | 1 | Clock phase: 0 captures on leading edge, 1 on trailing edge |
| sck_i | input | 1 | Serial clock from master (asynchronous) |
| mosi_i | input | 1 | Serial data from master (asynchronous) |
| ss_n_i | input | 1 | Active-low slave select (asynchronous) |
| miso_o | output | 1 | Serial data to master |
| miso_oe_o | output | 1 | Output enable for miso_o; low means high-impedance |
| wr_en_i | input | 1 | Host write strobe for the data register |
| wr_data_i | input | 8 | Host write data |
| rd_en_i | input | 1 | Host read strobe; clears the done flag |
| rd_data_o | output | 8 | Last received byte |
| xfer_done_o | output | 1 | Byte complete flag |
| collide_o | output | 1 | Sticky write-collision flag |
| collide_clr_i | input | 1 | Clears the collision flag |

## Verification
The assertions assume that the configuration bits change only while select is high, and that each serial clock half-period spans several system clocks. Under these assumptions no capture edge and shift edge fall in the same cycle. The output-enable property also assumes that the three-stage latency from select to state holds. The bench acts as a master with a half-period of eight system clocks and changes mode only with select high. It lets several cycles pass after each select change before the next clock edge, so every pin change reaches the synchronizers well apart from the others.

// File: rtl/spi_slv_pkg.sv
package spi_slv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_XFER = 2'd1,
        ST_HOLD = 2'd2
    } slv_state_e;

    typedef struct packed {
        logic cap;
        logic drv;
    } sck_evt_t;

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain <= {STAGES{RST_VAL[b]}};
            end else begin
                chain <= {chain[STAGES-2:0], d_i[b]};
            end
        end

        assign q_o[b] = chain[STAGES-1];
    end

endmodule

// File: rtl/spi_edge_classify.sv
module spi_edge_classify
    import spi_slv_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sck_s_i,
    input  logic     cpol_i,
    input  logic     cpha_i,
    output sck_evt_t evt_o
);

    logic sck_d;
    logic rise;
    logic fall;
    logic lead;
    logic trail;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_d <= 1'b0;
        end else begin
            sck_d <= sck_s_i;
        end
    end

    always_comb begin
        rise      = sck_s_i & ~sck_d;
        fall      = ~sck_s_i & sck_d;
        lead      = cpol_i ? fall : rise;
        trail     = cpol_i ? rise : fall;
        evt_o.cap = cpha_i ? trail : lead;
        evt_o.drv = cpha_i ? lead : trail;
    end

endmodule

// File: rtl/spi_slv_fsm.sv
module spi_slv_fsm
    import spi_slv_pkg::*;
#(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ss_n_s_i,
    input  logic            mosi_s_i,
    input  logic            cpha_i,
    input  sck_evt_t        evt_i,
    input  logic [BITS-1:0] load_i,
    output logic            busy_o,
    output logic            miso_bit_o,
    output logic            done_o,
    output logic [BITS-1:0] rx_byte_o
);

    localparam int CW = $clog2(BITS);
    localparam logic [CW-1:0] LAST = CW'(BITS - 1);

    slv_state_e      state_q;
    slv_state_e      state_nx;
    logic [CW-1:0]   cnt_q;
    logic [BITS-2:0] rx_sh_q;
    logic [BITS-1:0] tx_sh_q;
    logic            last_cap;

    assign last_cap = (state_q == ST_XFER) && evt_i.cap && (cnt_q == LAST);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ss_n_s_i) state_nx = ST_XFER;
            end
            ST_XFER: begin
                if (ss_n_s_i) begin
                    state_nx = ST_IDLE;
                end else if (last_cap && !cpha_i) begin
                    state_nx = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (ss_n_s_i) state_nx = ST_IDLE;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            rx_sh_q <= '0;
            tx_sh_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    cnt_q   <= '0;
                    tx_sh_q <= load_i;
                end
                ST_XFER: begin
                    if (evt_i.cap) begin
                        rx_sh_q <= rx_byte_o[BITS-2:0];
                        if (cnt_q == LAST) begin
                            cnt_q <= '0;
                            if (cpha_i) tx_sh_q <= load_i;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end else if (evt_i.drv) begin
                        if (!cpha_i || (cnt_q != '0)) begin
                            tx_sh_q <= {tx_sh_q[BITS-2:0], 1'b0};
                        end
                    end
                end
                ST_HOLD: begin
                    cnt_q <= '0;
                end
                default: begin
                    cnt_q <= '0;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        busy_o     = (state_q != ST_IDLE);
        miso_bit_o = tx_sh_q[BITS-1];
        done_o     = last_cap;
        rx_byte_o  = {rx_sh_q, mosi_s_i};
    end

endmodule

// File: rtl/spi_host_regs.sv
module spi_host_regs #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en_i,
    input  logic [BITS-1:0] wr_data_i,
    input  logic            rd_en_i,
    input  logic            clr_i,
    input  logic            lock_i,
    input  logic            done_i,
    input  logic [BITS-1:0] rx_byte_i,
    output logic [BITS-1:0] data_q_o,
    output logic [BITS-1:0] rx_q_o,
    output logic            done_flag_o,
    output logic            collide_flag_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q_o <= '0;
        end else if (wr_en_i && !lock_i) begin
            data_q_o <= wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q_o <= '0;
        end else if (done_i) begin
            rx_q_o <= rx_byte_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_flag_o <= 1'b0;
        end else if (done_i) begin
            done_flag_o <= 1'b1;
        end else if (rd_en_i) begin
            done_flag_o <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            collide_flag_o <= 1'b0;
        end else if (wr_en_i && lock_i) begin
            collide_flag_o <= 1'b1;
        end else if (clr_i) begin
            collide_flag_o <= 1'b0;
        end
    end

endmodule

// File: rtl/spi_byte_slave.sv
module spi_byte_slave
    import spi_slv_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cpol_i,
    input  logic              cfg_cpha_i,
    input  logic              sck_i,
    input  logic              mosi_i,
    input  logic              ss_n_i,
    output logic              miso_o,
    output logic              miso_oe_o,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              xfer_done_o,
    output logic              collide_o,
    input  logic              collide_clr_i
);

    localparam int PINS = 3;

    logic [PINS-1:0]   pins_s;
    logic              sck_s;
    logic              mosi_s;
    logic              ss_n_s;
    sck_evt_t          evt;
    logic              xfer_busy;
    logic              miso_bit;
    logic              byte_done;
    logic [DATA_W-1:0] rx_byte;
    logic [DATA_W-1:0] data_q;

    spi_pin_sync #(
        .W       (PINS),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({ss_n_i, mosi_i, sck_i}),
        .q_o   (pins_s)
    );

    assign sck_s  = pins_s[0];
    assign mosi_s = pins_s[1];
    assign ss_n_s = pins_s[2];

    spi_edge_classify u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_s_i (sck_s),
        .cpol_i  (cfg_cpol_i),
        .cpha_i  (cfg_cpha_i),
        .evt_o   (evt)
    );

    spi_slv_fsm #(
        .BITS (DATA_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .ss_n_s_i   (ss_n_s),
        .mosi_s_i   (mosi_s),
        .cpha_i     (cfg_cpha_i),
        .evt_i      (evt),
        .load_i     (data_q),
        .busy_o     (xfer_busy),
        .miso_bit_o (miso_bit),
        .done_o     (byte_done),
        .rx_byte_o  (rx_byte)
    );

    spi_host_regs #(
        .BITS (DATA_W)
    ) u_regs (
        .clk            (clk),
        .rst_n          (rst_n),
        .wr_en_i        (wr_en_i),
        .wr_data_i      (wr_data_i),
        .rd_en_i        (rd_en_i),
        .clr_i          (collide_clr_i),
        .lock_i         (xfer_busy | ~ss_n_s),
        .done_i         (byte_done),
        .rx_byte_i      (rx_byte),
        .data_q_o       (data_q),
        .rx_q_o         (rd_data_o),
        .done_flag_o    (xfer_done_o),
        .collide_flag_o (collide_o)
    );

    assign miso_oe_o = xfer_busy;
    assign miso_o    = xfer_busy ? miso_bit : 1'b0;

endmodule

// File: rtl/spi_byte_slave_chk.sv
module spi_byte_slave_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ss_n_i,
    input logic              miso_oe_o,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic              collide_clr_i,
    input logic              xfer_done_o,
    input logic              collide_o,
    input logic              busy,
    input logic [DATA_W-1:0] data_q
);

    // R10
    oe_off_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ss_n_i && $past(ss_n_i) && $past(ss_n_i, 2) && $past(ss_n_i, 3) && $past(ss_n_i, 4))
        |-> !miso_oe_o);

    // R6
    collide_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(collide_o) |-> $past(wr_en_i));

    // R6
    data_frozen_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(data_q));

    // R7
    collide_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(collide_o) |-> $past(collide_clr_i));

    // R5
    done_cleared_by_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(xfer_done_o) |-> $past(rd_en_i));

    // R11
    done_only_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(xfer_done_o) |-> $past(busy));

endmodule

bind spi_byte_slave spi_byte_slave_chk #(.DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ss_n_i        (ss_n_i),
    .miso_oe_o     (miso_oe_o),
    .wr_en_i       (wr_en_i),
    .rd_en_i       (rd_en_i),
    .collide_clr_i (collide_clr_i),
    .xfer_done_o   (xfer_done_o),
    .collide_o     (collide_o),
    .busy          (xfer_busy),
    .data_q        (data_q)
);

// File: tb/spi_byte_slave_bench.sv
`timescale 1ns/1ps
module spi_byte_slave_bench;

    localparam int HALF = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cpol = 1'b0;
    logic       cpha = 1'b0;
    logic       sck = 1'b0;
    logic       mosi = 1'b0;
    logic       ss_n = 1'b1;
    logic       miso;
    logic       miso_oe;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       done;
    logic       collide;
    logic       clr = 1'b0;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    spi_byte_slave u_spi_byte_slave (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_cpol_i    (cpol),
        .cfg_cpha_i    (cpha),
        .sck_i         (sck),
        .mosi_i        (mosi),
        .ss_n_i        (ss_n),
        .miso_o        (miso),
        .miso_oe_o     (miso_oe),
        .wr_en_i       (wr_en),
        .wr_data_i     (wr_data),
        .rd_en_i       (rd_en),
        .rd_data_o     (rd_data),
        .xfer_done_o   (done),
        .collide_o     (collide),
        .collide_clr_i (clr)
    );

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic host_read();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_mode(input logic pol, input logic pha);
        cpol = pol;
        cpha = pha;
        sck  = pol;
        wait_clk(6);
    endtask

    // Master side: shifts nb bits MSB first, returns what it sampled on miso.
    task automatic master_bits(input logic [7:0] tx, input int nb, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 7; i > 7 - nb; i--) begin
            if (!cpha) begin
                mosi = tx[i];
                wait_clk(HALF);
                rx[i] = miso;
                sck = ~sck;
                wait_clk(HALF);
                sck = ~sck;
            end else begin
                sck = ~sck;
                mosi = tx[i];
                wait_clk(HALF);
                rx[i] = miso;
                sck = ~sck;
                wait_clk(HALF);
            end
        end
    endtask

    task automatic ss_low();
        ss_n = 1'b0;
        wait_clk(HALF);
    endtask

    task automatic ss_high();
        wait_clk(HALF);
        ss_n = 1'b1;
        wait_clk(6);
    endtask

    task automatic t_reset();
        check("R1 oe", miso_oe, 0);
        check("R1 done", done, 0);
        check("R1 collide", collide, 0);
        check("R1 rd_data", rd_data, 8'h00);
    endtask

    task automatic t_mode(input logic pol, input logic pha, input logic [7:0] wd, input logic [7:0] md);
        logic [7:0] got;
        set_mode(pol, pha);
        host_write(wd);
        check("R12 collide after idle write", collide, 0);
        ss_low();
        master_bits(md, 8, got);
        check("R2 miso byte", got, wd);
        ss_high();
        check("R2/R5 rd_data", rd_data, md);
        check("R5 done set", done, 1);
        host_read();
        check("R5 done cleared", done, 0);
    endtask

    task automatic t_msb_early();
        logic [7:0] got;
        set_mode(1'b0, 1'b0);
        host_write(8'h80);
        ss_n = 1'b0;
        wait_clk(4);
        check("R3 oe after select", miso_oe, 1);
        check("R3 msb before edge", miso, 1);
        wait_clk(HALF - 4);
        master_bits(8'h00, 8, got);
        check("R3 shifted bits", got, 8'h80);
        ss_high();
        host_read();
    endtask

    task automatic t_cpha1_lead();
        logic [7:0] got;
        set_mode(1'b1, 1'b1);
        host_write(8'hC3);
        ss_low();
        master_bits(8'h96, 8, got);
        check("R4 lead-edge data", got, 8'hC3);
        ss_high();
        host_read();
    endtask

    task automatic t_collision();
        logic [7:0] got;
        set_mode(1'b0, 1'b1);
        host_write(8'h5A);
        check("R12 no collide", collide, 0);
        ss_low();
        host_write(8'hFF);
        wait_clk(2);
        check("R6 collide set", collide, 1);
        master_bits(8'h12, 8, got);
        check("R6 old byte sent", got, 8'h5A);
        ss_high();
        check("R7 still set", collide, 1);
        ss_low();
        master_bits(8'h34, 8, got);
        check("R6 data reg unchanged", got, 8'h5A);
        ss_high();
        host_read();
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R7 cleared", collide, 0);
    endtask

    task automatic t_b2b();
        logic [7:0] got;
        set_mode(1'b0, 1'b1);
        host_write(8'hE7);
        ss_low();
        master_bits(8'h11, 8, got);
        check("R9 first miso", got, 8'hE7);
        wait_clk(HALF);
        check("R9 first done", done, 1);
        check("R9 first rx", rd_data, 8'h11);
        host_read();
        wait_clk(HALF);
        master_bits(8'h22, 8, got);
        check("R9 second miso", got, 8'hE7);
        ss_high();
        check("R9 second done", done, 1);
        check("R9 second rx", rd_data, 8'h22);
        check("R9 no collide", collide, 0);
        host_read();
    endtask

    task automatic t_cpha0_hold();
        logic [7:0] got;
        set_mode(1'b1, 1'b0);
        host_write(8'h3C);
        ss_low();
        master_bits(8'h81, 8, got);
        check("R2 mode3 miso", got, 8'h3C);
        host_read();
        wait_clk(HALF);
        master_bits(8'h7E, 8, got);
        check("R8 no second done", done, 0);
        check("R8 rx keeps first", rd_data, 8'h81);
        ss_high();
        check("R8 still no done", done, 0);
    endtask

    task automatic t_ss_high_ignored();
        logic [7:0] got;
        set_mode(1'b0, 1'b0);
        master_bits(8'hF0, 8, got);
        wait_clk(HALF);
        check("R10 oe off", miso_oe, 0);
        check("R10 done untouched", done, 0);
        check("R10 rx untouched", rd_data, 8'h81);
    endtask

    task automatic t_abort();
        logic [7:0] got;
        set_mode(1'b0, 1'b0);
        host_write(8'hA0);
        ss_low();
        master_bits(8'hFF, 4, got);
        sck = cpol;
        ss_high();
        check("R11 no done", done, 0);
        check("R11 rx kept", rd_data, 8'h81);
        ss_low();
        master_bits(8'h0F, 8, got);
        ss_high();
        check("R11 fresh frame rx", rd_data, 8'h0F);
        check("R11 fresh frame miso", got, 8'hA0);
        host_read();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait_clk(4);
        t_reset();
        rst_n = 1'b1;
        wait_clk(4);
        t_reset();
        t_mode(1'b0, 1'b0, 8'hA5, 8'h3C);
        t_mode(1'b0, 1'b1, 8'h69, 8'hB4);
        t_mode(1'b1, 1'b0, 8'h0F, 8'hF1);
        t_mode(1'b1, 1'b1, 8'hD2, 8'h2D);
        t_msb_early();
        t_cpha1_lead();
        t_collision();
        t_b2b();
        t_cpha0_hold();
        host_read();
        t_ss_high_ignored();
        t_abort();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule